// File: doc/BRIEF.md
# Profiling Time Window Controller

This block produces one level, `win_active`, that opens and closes the measurement window of a bank of profiling counters. The window can be driven in two ways. In edge mode, a rising edge on a hardware trigger or a one-cycle software command opens or closes it. In level mode, the window simply follows the hardware start line and every other source is ignored. The same level is also the status bit that software reads.

A global enable gates everything. While it is low, the window is held closed. A trigger level that is already high when the block is enabled is not taken as an edge. The triggers are assumed to be synchronous to `clk`.

Every decision is registered. The output therefore reflects the inputs sampled at the previous rising clock edge.

Top module: `prof_window_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released with all inputs low, `win_active` is 0.
- R2: In edge mode (`cfg_level_mode`=0, `cfg_enable`=1), a 0-to-1 change of `hw_start` between two consecutive clock edges sets `win_active` to 1 after the second edge, unless a stop event occurs in the same cycle.
- R3: In edge mode, a 0-to-1 change of `hw_stop` clears `win_active` after that clock edge.
- R4: In edge mode, a stop event always beats a start event in the same cycle. A stop event is a rising `hw_stop` or `sw_stop`; a start event is a rising `hw_start` or `sw_start`. This holds for every combination of the two.
- R5: In edge mode, a trigger held high is not a new edge. With no event in a cycle, `win_active` keeps its value.
- R6: In level mode (`cfg_level_mode`=1, `cfg_enable`=1), `win_active` equals the `hw_start` level sampled at the previous clock edge, and `hw_stop` has no effect.
- R7: In edge mode, a one-cycle `sw_start` opens the window and a one-cycle `sw_stop` closes it.
- R8: In level mode, `sw_start` and `sw_stop` have no effect on `win_active`.
- R9: With `cfg_enable`=0, `win_active` is 0 after the next clock edge. Edges and commands seen while disabled are dropped. A trigger already high at re-enable is not an edge, so the window stays closed after re-enable.
- R10: When the mode changes from level to edge, the window keeps its current state until the next event. When the mode changes from edge to level, the window follows `hw_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Global enable; 0 holds the window closed |
| cfg_level_mode | input | 1 | 0 = edge mode, 1 = level mode |
| hw_start | input | 1 | Hardware start trigger (level in level mode) |
| hw_stop | input | 1 | Hardware stop trigger, used only in edge mode |
| sw_start | input | 1 | One-cycle software start command |
| sw_stop | input | 1 | One-cycle software stop command |
| win_active | output | 1 | Window open (1) or closed (0) |

## Verification
The main function is tried with several patterns:
- Isolated rising edges of each trigger separate edge detection from simple level sampling.
- Triggers held high over several cycles expose any re-triggering on a level.
- Every pairing of start and stop sources in one cycle confirms that stop always wins, whether the sources are hardware, software or mixed.
- Level-mode sequences with stop pulses and software commands show that only `hw_start` steers the window.
- Mode switches with the window open tell state retention apart from state reloading.
- Disable and re-enable with a trigger already high distinguishes true edges from the first sample after enable.

// File: rtl/pwc_pkg.sv
// Shared types for the profiling time window controller.
// Assumes nothing beyond a single synchronous clock domain.
package pwc_pkg;
    typedef enum logic {
        WIN_EDGE  = 1'b0,
        WIN_LEVEL = 1'b1
    } win_mode_e;

    localparam int unsigned TRIG_NUM = 2;
    localparam int unsigned TRIG_START = 0;
    localparam int unsigned TRIG_STOP = 1;
endpackage

// File: rtl/pwc_edge_det.sv
// Rising-edge detector, one lane per bit.
// Each lane compares its input with a copy registered on the previous clock.
// The copies reset to 0 and keep sampling whether or not the block is enabled.
module pwc_edge_det #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        // Keep the previous sample of this lane
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= level_i[g];
        end

        // A lane rises when it is high now and was low before
        always_comb rise_o[g] = level_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/pwc_event_merge.sv
// Combines hardware edges and software commands into one start event and one stop event.
// Software commands pass only in edge mode. Assumes they are single-cycle pulses.
module pwc_event_merge
    import pwc_pkg::*;
(
    input  win_mode_e mode_i,
    input  logic      hw_start_rise_i,
    input  logic      hw_stop_rise_i,
    input  logic      sw_start_i,
    input  logic      sw_stop_i,
    output logic      start_ev_o,
    output logic      stop_ev_o
);
    logic sw_pass;

    // Software commands are honoured in edge mode only
    always_comb sw_pass = (mode_i == WIN_EDGE);

    // Gather the sources of each kind of event
    always_comb begin
        start_ev_o = hw_start_rise_i | (sw_pass & sw_start_i);
        stop_ev_o  = hw_stop_rise_i  | (sw_pass & sw_stop_i);
    end
endmodule

// File: rtl/pwc_win_state.sv
// Holds the window state register.
// In edge mode, a stop event beats a start event, and with no event the state is held.
// In level mode, the state follows the start level.
// With enable low, the state is cleared.
module pwc_win_state
    import pwc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable_i,
    input  win_mode_e mode_i,
    input  logic      start_level_i,
    input  logic      start_ev_i,
    input  logic      stop_ev_i,
    output logic      win_o
);
    logic win_q;
    logic win_d;

    // Next-state selection: disable, then mode, then stop-over-start priority
    always_comb begin
        win_d = win_q;
        if (!enable_i) begin
            win_d = 1'b0;
        end else if (mode_i == WIN_LEVEL) begin
            win_d = start_level_i;
        end else if (stop_ev_i) begin
            win_d = 1'b0;
        end else if (start_ev_i) begin
            win_d = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= 1'b0;
        else        win_q <= win_d;
    end

    always_comb win_o = win_q;
endmodule

// File: rtl/prof_window_ctrl.sv
// Top of the profiling time window controller.
// Detects trigger edges, merges them with software commands and drives the registered
// window level. Assumes the triggers are already synchronous to clk.
module prof_window_ctrl
    import pwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_enable,
    input  logic cfg_level_mode,
    input  logic hw_start,
    input  logic hw_stop,
    input  logic sw_start,
    input  logic sw_stop,
    output logic win_active
);
    logic [TRIG_NUM-1:0] trig_level;
    logic [TRIG_NUM-1:0] trig_rise;
    win_mode_e           mode;
    logic                start_ev;
    logic                stop_ev;

    // Pack the triggers into lanes and decode the mode
    always_comb begin
        trig_level[TRIG_START] = hw_start;
        trig_level[TRIG_STOP]  = hw_stop;
        mode = win_mode_e'(cfg_level_mode);
    end

    pwc_edge_det #(.WIDTH(TRIG_NUM)) i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (trig_level),
        .rise_o  (trig_rise)
    );

    pwc_event_merge i_merge (
        .mode_i          (mode),
        .hw_start_rise_i (trig_rise[TRIG_START]),
        .hw_stop_rise_i  (trig_rise[TRIG_STOP]),
        .sw_start_i      (sw_start),
        .sw_stop_i       (sw_stop),
        .start_ev_o      (start_ev),
        .stop_ev_o       (stop_ev)
    );

    pwc_win_state i_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (cfg_enable),
        .mode_i        (mode),
        .start_level_i (hw_start),
        .start_ev_i    (start_ev),
        .stop_ev_i     (stop_ev),
        .win_o         (win_active)
    );
endmodule

// File: rtl/pwc_checker.sv
// Property checker for prof_window_ctrl, bound to every instance of it.
// Keeps its own copies of the trigger levels to judge rising edges from the ports.
module pwc_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic cfg_level_mode,
    input logic hw_start,
    input logic hw_stop,
    input logic sw_start,
    input logic sw_stop,
    input logic win_active
);
    logic start_seen_q;
    logic stop_seen_q;
    logic start_up;
    logic stop_up;
    logic edge_on;

    // Trigger history seen from the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_seen_q <= 1'b0;
            stop_seen_q  <= 1'b0;
        end else begin
            start_seen_q <= hw_start;
            stop_seen_q  <= hw_stop;
        end
    end

    // Edges seen from the ports and the edge-mode condition
    always_comb begin
        start_up = hw_start & ~start_seen_q;
        stop_up  = hw_stop & ~stop_seen_q;
        edge_on  = cfg_enable & ~cfg_level_mode;
    end

    assert_disable_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !win_active);

    assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_level_mode) |=> (win_active == $past(hw_start)));

    assert_sw_ignored_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_level_mode && !hw_start && sw_start) |=> !win_active);

    assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_on && (sw_stop || stop_up)) |=> !win_active);

    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_on && (sw_start || start_up) && !sw_stop && !stop_up) |=> win_active);

    assert_hold_no_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_on && !sw_start && !sw_stop && !start_up && !stop_up) |=> $stable(win_active));
endmodule

bind prof_window_ctrl pwc_checker i_pwc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_level_mode (cfg_level_mode),
    .hw_start       (hw_start),
    .hw_stop        (hw_stop),
    .sw_start       (sw_start),
    .sw_stop        (sw_stop),
    .win_active     (win_active)
);

// File: tb/test_prof_window_ctrl.sv
module test_prof_window_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 34;
    localparam int  WATCHDOG_CYCLES = 5000;

    // Vector: [10:7] requirement number, [6] enable, [5] level mode, [4] hw_start,
    // [3] hw_stop, [2] sw_start, [1] sw_stop, [0] expected win_active after the edge
    localparam logic [10:0] VEC [NVEC] = '{
        {4'd1,  7'b1000000},  // R1 idle
        {4'd2,  7'b1010001},  // R2 start rise opens
        {4'd5,  7'b1010001},  // R5 held high
        {4'd5,  7'b1000001},  // R5 no event holds
        {4'd3,  7'b1001000},  // R3 stop rise closes
        {4'd5,  7'b1001000},  // R5 stop held
        {4'd2,  7'b1010001},  // R2 reopen
        {4'd5,  7'b1010001},  // R5
        {4'd7,  7'b1010010},  // R7 sw stop closes, start still high
        {4'd5,  7'b1010000},  // R5 held start does not reopen
        {4'd7,  7'b1000101},  // R7 sw start opens
        {4'd5,  7'b1000001},  // R5
        {4'd4,  7'b1011000},  // R4 both hw rise together
        {4'd4,  7'b1000000},  // R4
        {4'd4,  7'b1000110},  // R4 both sw together
        {4'd4,  7'b1010010},  // R4 hw start rise with sw stop
        {4'd7,  7'b1000101},  // R7 sw start
        {4'd4,  7'b1001100},  // R4 hw stop rise with sw start
        {4'd6,  7'b1100000},  // R6 level mode, start low
        {4'd6,  7'b1110001},  // R6 follows start high
        {4'd6,  7'b1111011},  // R6 hw stop and sw stop ignored
        {4'd8,  7'b1100100},  // R8 sw start ignored
        {4'd6,  7'b1110001},  // R6
        {4'd10, 7'b1010001},  // R10 level to edge keeps open
        {4'd10, 7'b1000001},  // R10 still open
        {4'd10, 7'b1100000},  // R10 edge to level follows start
        {4'd9,  7'b0010000},  // R9 edge dropped while disabled
        {4'd9,  7'b0010100},  // R9 sw start dropped while disabled
        {4'd9,  7'b1010000},  // R9 high at re-enable is no edge
        {4'd9,  7'b1000000},  // R9
        {4'd2,  7'b1010001},  // R2 fresh edge opens
        {4'd9,  7'b0010000},  // R9 disable closes
        {4'd9,  7'b1010000},  // R9 stays closed after re-enable
        {4'd9,  7'b0110000}   // R9 level mode disabled
    };

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_enable, cfg_level_mode, hw_start, hw_stop, sw_start, sw_stop;
    logic win_active;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prof_window_ctrl i_prof_window_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_enable     (cfg_enable),
        .cfg_level_mode (cfg_level_mode),
        .hw_start       (hw_start),
        .hw_stop        (hw_stop),
        .sw_start       (sw_start),
        .sw_stop        (sw_stop),
        .win_active     (win_active)
    );

    task automatic check(input int req, input logic exp, input string what);
        checks++;
        if (win_active !== exp) begin
            failures++;
            $display("FAIL R%0d %s: win_active=%b expected=%b", req, what, win_active, exp);
        end
    endtask

    // Drive at the falling edge, pass one rising edge, sample just after it
    task automatic step(input logic [5:0] drv);
        @(negedge clk);
        {cfg_enable, cfg_level_mode, hw_start, hw_stop, sw_start, sw_stop} = drv;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cfg_enable, cfg_level_mode, hw_start, hw_stop, sw_start, sw_stop} = '0;
        repeat (3) @(posedge clk);
        #1;
        check(1, 1'b0, "during reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        {cfg_enable, cfg_level_mode, hw_start, hw_stop, sw_start, sw_stop} = '0;
        do_reset();
        step(6'b000000);
        check(1, 1'b0, "first sample after reset");

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][6:1]);
            check(int'(VEC[i][10:7]), VEC[i][0], $sformatf("vector %0d", i));
        end

        // R1: reset while the window is open closes it
        step(6'b100000);
        step(6'b101000);
        check(2, 1'b1, "open before reset");
        do_reset();
        step(6'b100000);
        check(1, 1'b0, "after mid-run reset");

        // R4: stop rise together with start rise, starting from an open window
        step(6'b100010);
        check(7, 1'b1, "sw start before combined edge");
        step(6'b100000);
        step(6'b101100);
        check(4, 1'b0, "combined rise closes open window");

        // R8: sw stop in level mode leaves an open window open
        step(6'b111000);
        check(6, 1'b1, "level open");
        step(6'b111001);
        check(8, 1'b1, "sw stop ignored in level mode");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule